// File: doc/BRIEF.md
# Row-Based Flash Programming Sequencer

This block writes a contiguous address range of a flash array with caller-supplied data, or drives every word of that range to zero. It walks the range one 32-word row at a time. On each pass over a row it reads every word back. A word that still holds a 1 in a bit that should be 0 receives one program pulse. The row is passed over again until a full pass applies no pulse. Only then does the sequencer move to the next row.

Each row has its own pulse budget. When a word needs a pulse and the budget for the current row is already spent, the operation stops and reports device failure with the first address of that row. Pulse width, programming voltages and array timing belong to the array side. From the sequencer's view, a pulse is one accepted request.

Target data comes from a combinational source that answers for the current `op_addr` in the same cycle. Requests to the array use valid/ready. `rd_valid` and `pgm_valid` stay high, with `op_addr` and `pgm_data` unchanged, until the matching ready is seen at a clock edge. Only one request is outstanding at a time. A read response arrives as a single-cycle `rd_rsp_valid` at any point after its request is accepted. The sequencer always accepts it and never stalls the response.

Top module: `flash_row_prog`

## Requirements
- R1: Out of reset, `busy`, `done`, `fail`, `rd_valid` and `pgm_valid` are all low and `fail_addr` is 0.
- R2: A word is treated as failing verify only when some bit reads 1 where the target holds 0. Bits that read 0 where the target holds 1 are ignored and cause no pulse.
- R3: On each pass, every failing word in the row gets exactly one program pulse, carrying the target data for that word. A pass that applies any pulse is followed by another pass over the same row, from its first in-range address. Each word therefore receives exactly as many pulses as it needs.
- R4: Rows are aligned 32-word blocks (address bits [4:0] equal 31 mark the row's last word). A row starts no earlier than `start_addr` and stops at `end_addr`. No read or pulse ever leaves [`start_addr`, `end_addr`]. After a clean pass, the next row starts at the following address.
- R5: The pulse count restarts at zero for each new row. If a word needs a pulse while the row's count equals the latched `max_pulses`, the operation ends with `fail`, and `fail_addr` takes the first in-range address of that row. A row needing exactly `max_pulses` pulses completes. `max_pulses` = 0 fails on the first failing word.
- R6: With `clear_mode` high at start, the target for every word is all zeros, whatever `src_data` holds.
- R7: `done` and `fail` are single-cycle pulses, never high together. `busy` goes high the cycle after an accepted start and stays high until the cycle in which `done` or `fail` appears, when it is low.
- R8: `rd_valid` and `pgm_valid` are never high together. Each holds, with `op_addr` (and `pgm_data` for a pulse) stable, until its ready is sampled high.
- R9: `start` while `busy` is ignored. The running range, data and budget are unchanged, and exactly one `done` follows.
- R10: If `start_addr` > `end_addr`, `done` pulses in the cycle after start, with no array access and `busy` staying low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| start_addr | input | ADDR_W | First address of the range |
| end_addr | input | ADDR_W | Last address of the range (inclusive) |
| clear_mode | input | 1 | Drive all targets to zero instead of using `src_data` |
| max_pulses | input | CNT_W | Pulse budget per row |
| src_data | input | DATA_W | Target data for `op_addr`, combinational |
| op_addr | output | ADDR_W | Address of the current read or pulse |
| pgm_data | output | DATA_W | Target data carried by a program pulse |
| rd_valid | output | 1 | Verify-read request |
| rd_ready | input | 1 | Array accepts the read request |
| rd_rsp_valid | input | 1 | Read data returned (one cycle) |
| rd_rsp_data | input | DATA_W | Word read from the array |
| pgm_valid | output | 1 | Program-pulse request |
| pgm_ready | input | 1 | Array accepts (and completes) the pulse |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Range programmed, single cycle |
| fail | output | 1 | Row budget exhausted, single cycle |
| fail_addr | output | ADDR_W | First address of the row that failed |

## Verification
The bench models an array in which every word needs one to three pulses before it takes its target. It then counts pulses per word. A design that re-pulses words already verified, or skips the repeat pass, shows a per-word count mismatch. Ranges that start and end mid-row, and a single-word range, expose row-edge errors: reads outside the range, or a repeat pass that restarts at the aligned row base instead of the first in-range address. Budgets exactly equal to and one below a row's need, a zero budget, and a second row that fails after a first row succeeds catch off-by-one budget checks, counters that are not reset per row, and a wrong `fail_addr`. Rerunning over programmed words with targets that have more 1s catches a verify compare that pulses on 0-where-1 bits. A mid-run start that moves the range, and an empty range, catch a sequencer that re-latches while busy or touches the array for nothing.

// File: rtl/frp_pkg.sv
package frp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_PULSE,
    ST_STEP
  } frp_state_e;
endpackage

// File: rtl/frp_verify.sv
// Verify compare: a word needs a pulse only where a bit reads 1 but should be 0.
module frp_verify #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] read_word,
  input  logic [DATA_W-1:0] target,
  output logic              needs_pulse
);
  logic [DATA_W-1:0] stuck_high;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign stuck_high[b] = read_word[b] & ~target[b];
  end

  assign needs_pulse = |stuck_high;
endmodule

// File: rtl/frp_budget.sv
// Per-row pulse counter; reports when the budget is used up.
module frp_budget #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic             spent
);
  logic [CNT_W-1:0] used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     used <= '0;
    else if (clear) used <= '0;
    else if (bump)  used <= used + 1'b1;
  end

  assign spent = (used == limit);
endmodule

// File: rtl/frp_walker.sv
// Address walker: current word, first word of the row pass, row and range edges.
module frp_walker #(
  parameter int ADDR_W    = 12,
  parameter int ROW_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] first_in,
  input  logic [ADDR_W-1:0] last_in,
  input  logic              next_word,
  input  logic              rewind,
  input  logic              next_row,
  output logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] row_first,
  output logic              pass_end,
  output logic              range_end
);
  localparam int ROW_BITS = $clog2(ROW_WORDS);

  logic [ADDR_W-1:0] last_q;
  logic              row_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur       <= '0;
      row_first <= '0;
      last_q    <= '0;
    end else if (load) begin
      cur       <= first_in;
      row_first <= first_in;
      last_q    <= last_in;
    end else if (next_row) begin
      cur       <= cur + 1'b1;
      row_first <= cur + 1'b1;
    end else if (rewind) begin
      cur       <= row_first;
    end else if (next_word) begin
      cur       <= cur + 1'b1;
    end
  end

  if (ROW_BITS == 0) begin : g_row1
    assign row_edge = 1'b1;
  end else begin : g_rowN
    assign row_edge = &cur[ROW_BITS-1:0];
  end

  assign range_end = (cur == last_q);
  assign pass_end  = range_end | row_edge;
endmodule

// File: rtl/flash_row_prog.sv
module flash_row_prog #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 8,
  parameter int ROW_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              clear_mode,
  input  logic [CNT_W-1:0]  max_pulses,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] pgm_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              pgm_valid,
  input  logic              pgm_ready,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  import frp_pkg::*;

  frp_state_e        st;
  logic              clr_q;
  logic [CNT_W-1:0]  limit_q;
  logic              row_ok;
  logic              done_q, fail_q;
  logic [ADDR_W-1:0] fail_addr_q;

  logic [ADDR_W-1:0] cur, row_first;
  logic              pass_end, range_end;
  logic              needs_pulse, spent;
  logic [DATA_W-1:0] target;

  logic load, next_word, rewind, next_row, budget_clr, budget_bump;

  assign target      = clr_q ? '0 : src_data;
  assign load        = (st == ST_IDLE) && start && (start_addr <= end_addr);
  assign next_word   = (st == ST_STEP) && !pass_end;
  assign rewind      = (st == ST_STEP) && pass_end && !row_ok;
  assign next_row    = (st == ST_STEP) && pass_end && row_ok && !range_end;
  assign budget_clr  = load || next_row;
  assign budget_bump = (st == ST_PULSE) && pgm_ready;

  frp_walker #(.ADDR_W(ADDR_W), .ROW_WORDS(ROW_WORDS)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .first_in  (start_addr),
    .last_in   (end_addr),
    .next_word (next_word),
    .rewind    (rewind),
    .next_row  (next_row),
    .cur       (cur),
    .row_first (row_first),
    .pass_end  (pass_end),
    .range_end (range_end)
  );

  frp_budget #(.CNT_W(CNT_W)) u_budget (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (budget_clr),
    .bump  (budget_bump),
    .limit (limit_q),
    .spent (spent)
  );

  frp_verify #(.DATA_W(DATA_W)) u_verify (
    .read_word   (rd_rsp_data),
    .target      (target),
    .needs_pulse (needs_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      clr_q       <= 1'b0;
      limit_q     <= '0;
      row_ok      <= 1'b1;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            if (start_addr > end_addr) begin
              done_q <= 1'b1;
            end else begin
              clr_q   <= clear_mode;
              limit_q <= max_pulses;
              row_ok  <= 1'b1;
              st      <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ: begin
          if (rd_ready) st <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (rd_rsp_valid) begin
            if (!needs_pulse) begin
              st <= ST_STEP;
            end else if (spent) begin
              fail_q      <= 1'b1;
              fail_addr_q <= row_first;
              st          <= ST_IDLE;
            end else begin
              st <= ST_PULSE;
            end
          end
        end
        ST_PULSE: begin
          if (pgm_ready) begin
            row_ok <= 1'b0;
            st     <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (!pass_end) begin
            st <= ST_RD_REQ;
          end else if (!row_ok) begin
            row_ok <= 1'b1;
            st     <= ST_RD_REQ;
          end else if (range_end) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            row_ok <= 1'b1;
            st     <= ST_RD_REQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign op_addr   = cur;
  assign pgm_data  = target;
  assign rd_valid  = (st == ST_RD_REQ);
  assign pgm_valid = (st == ST_PULSE);
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;
  assign fail_addr = fail_addr_q;
endmodule

// File: rtl/frp_checks.sv
module frp_checks #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] op_addr,
  input logic [DATA_W-1:0] pgm_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              pgm_valid,
  input logic              pgm_ready,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr
);
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(op_addr));

  a_r8_pgm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid && !pgm_ready |=> pgm_valid && $stable(op_addr) && $stable(pgm_data));

  a_r8_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && pgm_valid));

  a_r7_exclusive_end: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fail}));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);

  a_r7_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);

  a_r7_request_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || pgm_valid) |-> busy);

  a_r5_fail_addr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fail_addr) |-> fail);
endmodule

bind flash_row_prog frp_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_addr   (op_addr),
  .pgm_data  (pgm_data),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .pgm_valid (pgm_valid),
  .pgm_ready (pgm_ready),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .fail_addr (fail_addr)
);

// File: tb/sim_flash_row_prog.sv
module sim_flash_row_prog;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int MEMN = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic          clear_mode = 1'b0;
  logic [CW-1:0] max_pulses = '0;
  logic [DW-1:0] src_data;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] pgm_data;
  logic          rd_valid, pgm_valid;
  logic          rd_ready = 1'b0, pgm_ready = 1'b0;
  logic          rd_rsp_valid = 1'b0;
  logic [DW-1:0] rd_rsp_data = '0;
  logic          busy, done, fail;
  logic [AW-1:0] fail_addr;

  logic [DW-1:0] mem  [MEMN];
  logic [DW-1:0] snap [MEMN];
  int            hits [MEMN];
  logic [DW-1:0] xmask = '0;
  int  n_checks = 0, n_fail = 0;
  int  pulse_total = 0, read_total = 0, oob = 0;
  int  win_lo = 0, win_hi = 0;
  int  cyc = 0;
  bit  rd_pend = 0, pg_pend = 0;
  int  rd_a = 0, pg_a = 0;
  logic [DW-1:0] pg_d = '0;

  function automatic logic [DW-1:0] pat(input int a);
    logic [31:0] v;
    v = a * 32'h3B1D;
    return (v[DW-1:0] ^ 16'hC3A5) | xmask;
  endfunction

  function automatic int need(input int a);
    return 1 + (a % 3);
  endfunction

  assign src_data = pat(int'(op_addr));

  flash_row_prog #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .ROW_WORDS(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .end_addr(end_addr), .clear_mode(clear_mode), .max_pulses(max_pulses),
    .src_data(src_data), .op_addr(op_addr), .pgm_data(pgm_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .pgm_valid(pgm_valid), .pgm_ready(pgm_ready),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Array model: a word takes its target only after need(a) pulses.
  initial begin
    forever begin
      @(negedge clk);
      if (rd_pend) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem[rd_a];
      end else begin
        rd_rsp_valid = 1'b0;
      end
      if (pg_pend) begin
        hits[pg_a]++;
        pulse_total++;
        if (hits[pg_a] >= need(pg_a)) mem[pg_a] = mem[pg_a] & pg_d;
      end
      rd_pend = 0;
      pg_pend = 0;
      cyc++;
      rd_ready  = (cyc % 3) != 1;
      pgm_ready = (cyc % 4) != 2;
      if (rd_valid && rd_ready) begin
        rd_pend = 1;
        rd_a = int'(op_addr) % MEMN;
        read_total++;
        if (int'(op_addr) < win_lo || int'(op_addr) > win_hi) oob++;
      end
      if (pgm_valid && pgm_ready) begin
        pg_pend = 1;
        pg_a = int'(op_addr) % MEMN;
        pg_d = pgm_data;
        if (int'(op_addr) < win_lo || int'(op_addr) > win_hi) oob++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int a = 0; a < MEMN; a++) begin
      mem[a] = '1;
      hits[a] = 0;
    end
    xmask = '0;
  endtask

  task automatic take_snap();
    for (int a = 0; a < MEMN; a++) begin
      snap[a] = mem[a];
      hits[a] = 0;
    end
    pulse_total = 0;
    read_total = 0;
    oob = 0;
  endtask

  task automatic expect_of(input int lo, input int hi, input bit clr, input int maxp,
                           output bit ef, output int efa, output int ep);
    int rowsum, rfirst;
    logic [DW-1:0] t;
    ef = 0; efa = 0; ep = 0; rowsum = 0; rfirst = lo;
    for (int a = lo; a <= hi; a++) begin
      t = clr ? '0 : pat(a);
      if ((snap[a] & ~t) != '0) rowsum += need(a);
      if (a == hi || (a % 32) == 31) begin
        if (rowsum > maxp) begin
          ef = 1; efa = rfirst; ep += maxp;
          break;
        end
        ep += rowsum;
        rowsum = 0;
        rfirst = a + 1;
      end
    end
  endtask

  // Runs one operation; poke>0 pulses start again (with another range) that many cycles in.
  task automatic run_op(input int lo, input int hi, input bit clr, input int maxp,
                        input int poke, output bit gd, output bit gf,
                        output int cycles, output int gaps, output int dwidth);
    gd = 0; gf = 0; cycles = 0; gaps = 0; dwidth = 0;
    win_lo = lo; win_hi = hi;
    @(negedge clk);
    start_addr = AW'(lo); end_addr = AW'(hi);
    clear_mode = clr; max_pulses = CW'(maxp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    start_addr = '0; end_addr = '0; clear_mode = 1'b0; max_pulses = '0;
    cycles = 1;
    while (!(done || fail) && cycles < 60000) begin
      if (!busy) gaps++;
      if (poke > 0 && cycles == poke) begin
        start_addr = AW'(12'h100); end_addr = AW'(12'h110);
        clear_mode = 1'b1; max_pulses = CW'(200);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    gd = done; gf = fail;
    if (busy) gaps++;
    while (done || fail) begin
      dwidth++;
      @(negedge clk);
    end
  endtask

  task automatic check_run(input string req, input int lo, input int hi,
                           input bit clr, input int maxp, input int poke);
    bit ef, gd, gf;
    int efa, ep, cyc_n, gaps, dw, bad_mem, bad_hits;
    logic [DW-1:0] t, em;
    take_snap();
    expect_of(lo, hi, clr, maxp, ef, efa, ep);
    run_op(lo, hi, clr, maxp, poke, gd, gf, cyc_n, gaps, dw);
    chk(gd == !ef && gf == ef, req, "done/fail outcome (fail bit)", int'(gf), int'(ef));
    chk(gaps == 0, "R7", "busy low before end or high at end", gaps, 0);
    chk(dw == 1, "R7", "end pulse width", dw, 1);
    chk(pulse_total == ep, req, "pulses applied", pulse_total, ep);
    chk(oob == 0, "R4", "accesses outside range", oob, 0);
    if (ef) begin
      chk(int'(fail_addr) == efa, "R5", "fail_addr", int'(fail_addr), efa);
    end else begin
      bad_mem = 0; bad_hits = 0;
      for (int a = 0; a < MEMN; a++) begin
        t = clr ? '0 : pat(a);
        em = snap[a];
        if (a >= lo && a <= hi && (snap[a] & ~t) != '0) begin
          em = snap[a] & t;
          if (hits[a] != need(a)) bad_hits++;
        end else if (hits[a] != 0) begin
          bad_hits++;
        end
        if (mem[a] !== em) bad_mem++;
      end
      chk(bad_mem == 0, req, "words with wrong final content", bad_mem, 0);
      chk(bad_hits == 0, "R3", "words with wrong pulse count", bad_hits, 0);
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fail, "R1", "busy/done/fail after reset",
        int'({busy, done, fail}), 0);
    chk(!rd_valid && !pgm_valid, "R1", "requests after reset",
        int'({rd_valid, pgm_valid}), 0);
    chk(fail_addr == '0, "R1", "fail_addr after reset", int'(fail_addr), 0);
  endtask

  task automatic t_span();
    init_mem();
    check_run("R3", 'h1C, 'h45, 0, 200, 0);
  endtask

  task automatic t_single();
    init_mem();
    check_run("R4", 'h33, 'h33, 0, 10, 0);
  endtask

  task automatic t_clear();
    int nz;
    init_mem();
    check_run("R6", 'h60, 'h7F, 1, 200, 0);
    nz = 0;
    for (int a = 'h60; a <= 'h7F; a++) if (mem[a] != '0) nz++;
    chk(nz == 0, "R6", "nonzero words after clear", nz, 0);
  endtask

  task automatic t_ignore_ones();
    init_mem();
    check_run("R3", 'h40, 'h5F, 0, 200, 0);
    xmask = 16'h0F0F;
    check_run("R2", 'h40, 'h5F, 0, 0, 0);
    chk(pulse_total == 0, "R2", "pulses on 0-where-1 bits", pulse_total, 0);
    xmask = '0;
  endtask

  task automatic t_budget();
    bit ef; int efa, ep;
    init_mem();
    take_snap();
    expect_of('h80, 'h9F, 0, 255, ef, efa, ep);
    check_run("R5", 'h80, 'h9F, 0, ep, 0);
    init_mem();
    check_run("R5", 'h80, 'h9F, 0, ep - 1, 0);
    init_mem();
    check_run("R5", 'h9C, 'hBF, 0, 1 + need('h9C) + need('h9D) + need('h9E) + need('h9F) - 1, 0);
    init_mem();
    check_run("R5", 'h23, 'h50, 0, 0, 0);
  endtask

  task automatic t_empty();
    bit gd, gf; int c, g, dw;
    init_mem();
    take_snap();
    run_op('h50, 'h4F, 0, 5, 0, gd, gf, c, g, dw);
    chk(gd && !gf && c == 1, "R10", "cycles to done on empty range", c, 1);
    chk(read_total == 0 && pulse_total == 0, "R10", "array accesses",
        read_total + pulse_total, 0);
  endtask

  task automatic t_busy_start();
    int extra;
    init_mem();
    check_run("R9", 'h20, 'h3F, 0, 200, 25);
    extra = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy || done || fail) extra++;
    end
    chk(extra == 0, "R9", "activity after the single done", extra, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL R7 watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_span();
    t_single();
    t_clear();
    t_ignore_ones();
    t_budget();
    t_empty();
    t_busy_start();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule